// File: doc/BRIEF.md
# Debug Register Bank with Access Responses

This block is the storage and decode stage of a debug unit. A host reaches it over a small register port: each access brings an address and either a read strobe or a write strobe, and the write strobe also brings a 32-bit word. One clock later the block returns a response pulse. The pulse carries an ok/error flag and, for reads that succeed, a 32-bit read word.

Two parameterised windows of general words can be both read and written. The first is a scratch window for data exchange, with `DATA_COUNT` words starting at `DATA_BASE`. The second is a window for instruction-buffer words, with `PROG_SIZE` words starting at `PROG_BASE`. Three fixed registers sit beside the windows:

- A control word with a reset-time identity: a version field and an authenticated flag.
- An abstract status word that reports the data-window size.
- An access status word that reports the buffer-window size.

These three registers are read-only. Any other address, and any write outside the two windows, is refused with an error response.

The response path is a small state machine with four states:

- `ST_IDLE`: no response is pending.
- `ST_READ_OK`: a read hit a known address.
- `ST_WRITE_OK`: a write landed in a window.
- `ST_FAULT`: the access was refused.

Each cycle, the machine takes the transition named by that cycle's strobes and decode result. With no strobe it returns to `ST_IDLE`. A strobe in the next cycle moves it straight from one response state to another, so accesses may run back to back.

Top module: `dmreg_bank`

## Requirements
- R1: After reset, `rsp_valid` is low, and every word of both windows reads back as zero.
- R2: A read or write at an address from `DATA_BASE` to `DATA_BASE+DATA_COUNT-1` reaches data word (address − `DATA_BASE`). A write stores `wdata` there, and a later read returns it with an ok response.
- R3: A read or write at an address from `PROG_BASE` to `PROG_BASE+PROG_SIZE-1` reaches buffer word (address − `PROG_BASE`), with the same store and read-back behaviour as R2.
- R4: A read of `CTRL_ADDR` returns 0x0000_0081 with ok: version field [3:0] = 1 and authenticated flag bit 7 = 1. A write to it is refused with an error, and the value it reads afterwards is unchanged.
- R5: A read of `ACS_ADDR` returns `DATA_COUNT` in bits [4:0], with all other bits zero. A read of `PCS_ADDR` returns `PROG_SIZE` in bits [4:0], with all other bits zero. A write to either is refused with an error.
- R6: A read of any address that is in neither window and is none of the three named registers gives an error response with `rdata` = 0.
- R7: A refused write changes no word of either window.
- R8: Every strobe cycle produces exactly one `rsp_valid` pulse in the next cycle. A cycle with no strobe produces no pulse in the next cycle. Accesses may run back to back, one per cycle.
- R9: If `req_rd` and `req_wr` are both high in the same cycle, the response is an error, and no word is written.
- R10: A write that succeeds gives an ok response with `rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd | input | 1 | Read strobe, one cycle per access |
| req_wr | input | 1 | Write strobe, one cycle per access |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse, one cycle after the strobe |
| rsp_err | output | 1 | 1 = access refused, 0 = ok |
| rsp_rdata | output | 32 | Read data; zero for refused accesses and for writes |

## Verification
The assertions check on every cycle that each strobe is answered in the next cycle and that no pulse appears without a strobe. They also check that an error or a write never carries non-zero read data, that window words hold whenever no write enable is present, and that a write enable never points past its window. Only the bench's scenarios can show which addresses decode to which word, and that read-back values match earlier writes. The bench also shows the exact constants in the status registers and that refused writes leave the windows untouched, which requires reading those windows back afterwards.

// File: rtl/dmreg_pkg.sv
package dmreg_pkg;
    localparam int unsigned WORD_W = 32;

    typedef enum logic [2:0] {
        K_NONE,
        K_DATA,
        K_PROG,
        K_CTRL,
        K_ACS,
        K_PCS
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ_OK,
        ST_WRITE_OK,
        ST_FAULT
    } st_e;
endpackage

// File: rtl/dmreg_decode.sv
module dmreg_decode
    import dmreg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 7,
    parameter int unsigned DATA_BASE  = 4,
    parameter int unsigned DATA_COUNT = 2,
    parameter int unsigned PROG_BASE  = 32,
    parameter int unsigned PROG_SIZE  = 4,
    parameter int unsigned CTRL_ADDR  = 16,
    parameter int unsigned ACS_ADDR   = 22,
    parameter int unsigned PCS_ADDR   = 23,
    parameter int unsigned DIDX_W     = 1,
    parameter int unsigned PIDX_W     = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output kind_e             kind,
    output logic [DIDX_W-1:0] didx,
    output logic [PIDX_W-1:0] pidx
);
    logic [31:0] addr_ext;
    logic [31:0] d_off;
    logic [31:0] p_off;

    assign addr_ext = 32'(addr);
    // Wrap-around subtraction: an address below the base gives a huge offset.
    assign d_off    = addr_ext - 32'(DATA_BASE);
    assign p_off    = addr_ext - 32'(PROG_BASE);
    assign didx     = DIDX_W'(d_off);
    assign pidx     = PIDX_W'(p_off);

    always_comb begin
        kind = K_NONE;
        if (d_off < 32'(DATA_COUNT))          kind = K_DATA;
        else if (p_off < 32'(PROG_SIZE))      kind = K_PROG;
        else if (addr_ext == 32'(CTRL_ADDR))  kind = K_CTRL;
        else if (addr_ext == 32'(ACS_ADDR))   kind = K_ACS;
        else if (addr_ext == 32'(PCS_ADDR))   kind = K_PCS;
    end
endmodule

// File: rtl/dmreg_wordbank.sv
module dmreg_wordbank
    import dmreg_pkg::*;
#(
    parameter int unsigned COUNT = 2,
    parameter int unsigned IDX_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [COUNT-1:0][WORD_W-1:0] words;

    for (genvar g = 0; g < COUNT; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             words[g] <= '0;
            else if (we && (32'(idx) == 32'(g)))    words[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (32'(idx) < 32'(COUNT)) rdata = words[idx];
    end

    // R7: storage holds in any cycle without a write enable
    p_hold_without_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(words));
    // R2 / R3: a write enable always targets a word inside the window
    p_we_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (32'(idx) < 32'(COUNT)));
endmodule

// File: rtl/dmreg_bank.sv
module dmreg_bank
    import dmreg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 7,
    parameter int unsigned DATA_BASE  = 4,
    parameter int unsigned DATA_COUNT = 2,
    parameter int unsigned PROG_BASE  = 32,
    parameter int unsigned PROG_SIZE  = 4,
    parameter int unsigned CTRL_ADDR  = 16,
    parameter int unsigned ACS_ADDR   = 22,
    parameter int unsigned PCS_ADDR   = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata
);
    localparam int unsigned DIDX_W = $clog2(DATA_COUNT < 2 ? 2 : DATA_COUNT);
    localparam int unsigned PIDX_W = $clog2(PROG_SIZE < 2 ? 2 : PROG_SIZE);
    localparam logic [31:0] CTRL_VALUE = 32'h0000_0081;
    localparam logic [31:0] ACS_VALUE  = {27'd0, 5'(DATA_COUNT)};
    localparam logic [31:0] PCS_VALUE  = {27'd0, 5'(PROG_SIZE)};

    kind_e              kind;
    logic [DIDX_W-1:0]  didx;
    logic [PIDX_W-1:0]  pidx;
    logic [WORD_W-1:0]  d_rdata;
    logic [WORD_W-1:0]  p_rdata;
    logic               d_we;
    logic               p_we;
    logic               one_rd;
    logic               one_wr;

    st_e                state_q;
    st_e                state_d;
    logic [31:0]        rdata_q;
    logic [31:0]        rdata_d;

    dmreg_decode #(
        .ADDR_W(ADDR_W), .DATA_BASE(DATA_BASE), .DATA_COUNT(DATA_COUNT),
        .PROG_BASE(PROG_BASE), .PROG_SIZE(PROG_SIZE), .CTRL_ADDR(CTRL_ADDR),
        .ACS_ADDR(ACS_ADDR), .PCS_ADDR(PCS_ADDR),
        .DIDX_W(DIDX_W), .PIDX_W(PIDX_W)
    ) u_decode (
        .addr(req_addr), .kind(kind), .didx(didx), .pidx(pidx)
    );

    // Simultaneous strobes count as neither a read nor a write.
    assign one_rd = req_rd && !req_wr;
    assign one_wr = req_wr && !req_rd;
    assign d_we   = one_wr && (kind == K_DATA);
    assign p_we   = one_wr && (kind == K_PROG);

    dmreg_wordbank #(.COUNT(DATA_COUNT), .IDX_W(DIDX_W)) u_data (
        .clk(clk), .rst_n(rst_n), .we(d_we), .idx(didx),
        .wdata(req_wdata), .rdata(d_rdata)
    );

    dmreg_wordbank #(.COUNT(PROG_SIZE), .IDX_W(PIDX_W)) u_prog (
        .clk(clk), .rst_n(rst_n), .we(p_we), .idx(pidx),
        .wdata(req_wdata), .rdata(p_rdata)
    );

    // Next state and next response word
    always_comb begin
        state_d = ST_IDLE;
        rdata_d = '0;
        if (one_rd) begin
            unique case (kind)
                K_DATA:  begin state_d = ST_READ_OK; rdata_d = d_rdata;    end
                K_PROG:  begin state_d = ST_READ_OK; rdata_d = p_rdata;    end
                K_CTRL:  begin state_d = ST_READ_OK; rdata_d = CTRL_VALUE; end
                K_ACS:   begin state_d = ST_READ_OK; rdata_d = ACS_VALUE;  end
                K_PCS:   begin state_d = ST_READ_OK; rdata_d = PCS_VALUE;  end
                default: state_d = ST_FAULT;
            endcase
        end else if (one_wr) begin
            state_d = (kind == K_DATA || kind == K_PROG) ? ST_WRITE_OK : ST_FAULT;
        end else if (req_rd && req_wr) begin
            state_d = ST_FAULT;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= rdata_d;
        end
    end

    // Outputs from state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_READ_OK:  begin rsp_valid = 1'b1; rsp_rdata = rdata_q; end
            ST_WRITE_OK: rsp_valid = 1'b1;
            ST_FAULT:    begin rsp_valid = 1'b1; rsp_err = 1'b1; end
            default:     ;
        endcase
    end

    // R8: a strobe is answered in the next cycle
    p_strobe_answered_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd || req_wr) |=> rsp_valid);
    // R8: no pulse without a strobe in the previous cycle
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_rd || req_wr) |=> !rsp_valid);
    // R6: a refused access carries zero data
    p_err_zero_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'd0));
    // R10: a plain write returns zero data
    p_write_zero_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && !req_rd) |=> (rsp_rdata == 32'd0));
    // R9: both strobes together never write storage
    p_dual_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && req_wr) |-> !(d_we || p_we));
endmodule

// File: tb/tb_dmreg_bank.sv
module tb_dmreg_bank;
    localparam int unsigned AW = 7;
    localparam logic [6:0] DB = 7'h04, PB = 7'h20, CA = 7'h10, AA = 7'h16, PA = 7'h17;
    localparam int unsigned DC = 2, PS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_rd = 1'b0, req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct { logic err; logic [31:0] data; string tag; } exp_t;
    exp_t q[$];

    always #4 clk = ~clk; // 125 MHz

    dmreg_bank #(.ADDR_W(AW), .DATA_BASE(4), .DATA_COUNT(DC), .PROG_BASE(32),
                 .PROG_SIZE(PS), .CTRL_ADDR(16), .ACS_ADDR(22), .PCS_ADDR(23)) dut (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic acc(input logic rd, input logic wr, input logic [6:0] a,
                       input logic [31:0] wd, input logic eerr,
                       input logic [31:0] ed, input string tag);
        @(negedge clk);
        q.push_back('{eerr, ed, tag});
        req_rd = rd; req_wr = wr; req_addr = a; req_wdata = wd;
    endtask

    task automatic idle();
        @(negedge clk);
        req_rd = 1'b0; req_wr = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (q.size() == 0) begin
                failures++;
                $display("FAIL R8 unexpected response: actual err=%0b data=%h expected none",
                         rsp_err, rsp_rdata);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (rsp_err !== e.err || rsp_rdata !== e.data) begin
                    failures++;
                    $display("FAIL %s: actual err=%0b data=%h expected err=%0b data=%h",
                             e.tag, rsp_err, rsp_rdata, e.err, e.data);
                end
            end
        end
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: actual rsp_valid=%0b expected 0", rsp_valid);
        end
        // R1: windows reset to zero
        for (int i = 0; i < DC; i++) acc(1, 0, DB + 7'(i), 0, 0, 0, "R1");
        for (int i = 0; i < PS; i++) acc(1, 0, PB + 7'(i), 0, 0, 0, "R1");
        // R2 / R10: data window writes and read-back, back to back (R8)
        acc(0, 1, DB,     32'hA5A5_0001, 0, 0, "R10");
        acc(0, 1, DB + 1, 32'h1234_5678, 0, 0, "R2");
        acc(1, 0, DB,     0, 0, 32'hA5A5_0001, "R2");
        acc(1, 0, DB + 1, 0, 0, 32'h1234_5678, "R2");
        // R3: buffer window
        for (int i = 0; i < PS; i++) acc(0, 1, PB + 7'(i), 32'hC0DE_0000 + i, 0, 0, "R3");
        idle();
        for (int i = 0; i < PS; i++) acc(1, 0, PB + 7'(i), 0, 0, 32'hC0DE_0000 + i, "R3");
        // R4: control register
        acc(1, 0, CA, 0, 0, 32'h81, "R4");
        acc(0, 1, CA, 32'hFFFF_FFFF, 1, 0, "R4");
        acc(1, 0, CA, 0, 0, 32'h81, "R4");
        // R5: status registers
        acc(1, 0, AA, 0, 0, 32'(DC), "R5");
        acc(1, 0, PA, 0, 0, 32'(PS), "R5");
        acc(0, 1, AA, 32'h1F, 1, 0, "R5");
        acc(0, 1, PA, 32'h1F, 1, 0, "R5");
        // R6: unknown reads, including just past each window
        acc(1, 0, DB + 7'(DC), 0, 1, 0, "R6");
        acc(1, 0, PB + 7'(PS), 0, 1, 0, "R6");
        acc(1, 0, DB - 1,      0, 1, 0, "R6");
        acc(1, 0, 7'h7F,       0, 1, 0, "R6");
        // R7: refused writes, then confirm windows intact
        acc(0, 1, DB + 7'(DC), 32'hDEAD_BEEF, 1, 0, "R7");
        acc(0, 1, PB + 7'(PS), 32'hDEAD_BEEF, 1, 0, "R7");
        acc(0, 1, PB - 1,      32'hDEAD_BEEF, 1, 0, "R7");
        acc(1, 0, DB + 1, 0, 0, 32'h1234_5678, "R7");
        acc(1, 0, PB + 3, 0, 0, 32'hC0DE_0003, "R7");
        acc(1, 0, PB,     0, 0, 32'hC0DE_0000, "R7");
        // R9: both strobes at once
        acc(1, 1, DB, 32'h0BAD_0BAD, 1, 0, "R9");
        acc(1, 0, DB, 0, 0, 32'hA5A5_0001, "R9");
        // R8: quiet cycles produce no response
        repeat (4) idle();
        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R8 missing responses: actual %0d pending expected 0", q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule